// File: doc/BRIEF.md
# Downstream Port Fault and Thermal Manager

This block supervises the power switches of a group of downstream ports, four by default. Every port supplies a synchronous overcurrent flag from its current-sense comparator and a software- or pin-driven active-low enable. All ports share one unsigned 8-bit die temperature code in degrees Celsius. For each port the block drives a switch-enable and an active-low fault flag.

A short overcurrent indication, such as the inrush from charging a capacitive load, is filtered by a per-port counter. A fault is reported only when the condition lasts long enough. Temperature is handled by two trip points, each with hysteresis. Crossing the lower trip switches off only those ports that are in sustained overcurrent, and the other ports keep running. Crossing the upper trip switches off every port. Each lockout releases only after the die has cooled by the hysteresis amount. If the overload persists, the port therefore cycles on and off. A top-level power-ready input gates every switch.

Top module: `port_guard_top`

## Requirements
- R1: A port's switch enable is high exactly when its enable input is low, power-ready is high, and neither that port's thermal lockout nor the global lockout is set.
- R2: While power-ready is low, every switch enable is low whatever the other inputs are.
- R3: A port's fault output goes low (value 0) on the clock edge where its overcurrent flag has been sampled high on DEGLITCH_CYCLES consecutive edges (8 by default). A run that is one edge shorter reports nothing. A low sample restarts the count.
- R4: When a port's overcurrent flag drops and no thermal lockout is set, its fault output returns high on the next clock edge.
- R5: A sustained overcurrent with the temperature below the lower trip reports a fault but leaves the port's switch enabled.
- R6: With the temperature at or above TRIP_LO (140), a port in sustained overcurrent is locked off and faulted one edge later. Ports that are not in overcurrent stay on with their fault output high.
- R7: A port lockout from the lower trip holds while the overcurrent is gone, and stays until the temperature reaches TRIP_LO minus HYST (120) or less. It clears on the second edge after that.
- R8: With the temperature at or above TRIP_HI (150), every switch enable goes low and every fault output goes low after one clock edge.
- R9: The global lockout stays set while the temperature is above TRIP_HI minus HYST (130). It clears one edge after the temperature reaches that value or less.
- R10: Asserting reset at once clears every fault, deglitch count and lockout. All fault outputs go high without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_ready | input | 1 | High when the supply rail is good; gates all switches |
| en_n | input | NUM_PORTS | Active-low per-port enable |
| oc_raw | input | NUM_PORTS | Synchronous per-port overcurrent flag, high for overcurrent |
| die_temp | input | TEMP_W | Unsigned die temperature in degrees Celsius |
| sw_on | output | NUM_PORTS | Per-port switch enable, high turns the switch on |
| fault_n | output | NUM_PORTS | Per-port fault flag, low for overcurrent or overtemperature |

## Verification
The hardest situation to reach is a partial thermal shutdown. In that state some ports are locked off by the lower trip and their neighbours keep running. Reaching it needs a sustained overcurrent already filtered through the deglitch counter while the die sits between the two trips. The stimulus table reaches it in two ways. In the first, the temperature rises while a port already has a fault. In the second, two ports overload together while the die is still warm from an earlier upper-trip event and inside its hysteresis band. The table then walks the temperature down one degree short of each release point, and afterwards onto the release point, so that the boundaries of both hysteresis bands are checked.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic {
    BAND_COOL = 1'b0,
    BAND_HOT  = 1'b1
  } band_e;
endpackage

// File: rtl/pg_deglitch.sv
module pg_deglitch #(
  parameter int DEGLITCH_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_raw,
  output logic oc_flt
);
  localparam int CW = (DEGLITCH_CYCLES < 2) ? 1 : $clog2(DEGLITCH_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(DEGLITCH_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flt_q, flt_d;
  logic          cnt_en;

  assign cnt_en = oc_raw | (cnt_q != '0) | flt_q;

  always_comb begin
    cnt_d = cnt_q;
    flt_d = flt_q;
    if (!oc_raw) begin
      cnt_d = '0;
      flt_d = 1'b0;
    end else if (cnt_q == LAST) begin
      flt_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      flt_q <= flt_d;
    end
  end

  assign oc_flt = flt_q;
endmodule

// File: rtl/pg_therm_band.sv
module pg_therm_band
  import pg_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int TRIP   = 140,
  parameter int HYST   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] die_temp,
  output logic              hot
);
  localparam logic [TEMP_W-1:0] TRIP_V = TEMP_W'(TRIP);
  localparam logic [TEMP_W-1:0] REL_V  = TEMP_W'(TRIP - HYST);

  band_e band_q, band_d;

  always_comb begin
    band_d = band_q;
    if (die_temp >= TRIP_V) begin
      band_d = BAND_HOT;
    end else if (die_temp <= REL_V) begin
      band_d = BAND_COOL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= BAND_COOL;
    end else if (band_d != band_q) begin
      band_q <= band_d;
    end
  end

  assign hot = (band_q == BAND_HOT);
endmodule

// File: rtl/pg_port_lock.sv
module pg_port_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_lo,
  input  logic oc_flt,
  output logic locked
);
  logic lock_q, lock_d;
  logic lock_en;

  assign lock_en = lock_q | (hot_lo & oc_flt);

  always_comb begin
    if (hot_lo) begin
      lock_d = lock_q | oc_flt;
    end else begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/port_guard_top.sv
module port_guard_top #(
  parameter int NUM_PORTS       = 4,
  parameter int DEGLITCH_CYCLES = 8,
  parameter int TEMP_W          = 8,
  parameter int TRIP_LO         = 140,
  parameter int TRIP_HI         = 150,
  parameter int HYST            = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_ready,
  input  logic [NUM_PORTS-1:0] en_n,
  input  logic [NUM_PORTS-1:0] oc_raw,
  input  logic [TEMP_W-1:0]    die_temp,
  output logic [NUM_PORTS-1:0] sw_on,
  output logic [NUM_PORTS-1:0] fault_n
);
  logic                 rst_meta_q, rst_sync_q;
  logic                 rst_int_n;
  logic [NUM_PORTS-1:0] oc_flt;
  logic [NUM_PORTS-1:0] port_lock;
  logic                 hot_lo, hot_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign rst_int_n = rst_sync_q;

  pg_therm_band #(
    .TEMP_W (TEMP_W),
    .TRIP   (TRIP_LO),
    .HYST   (HYST)
  ) u_band_lo (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .die_temp (die_temp),
    .hot      (hot_lo)
  );

  pg_therm_band #(
    .TEMP_W (TEMP_W),
    .TRIP   (TRIP_HI),
    .HYST   (HYST)
  ) u_band_hi (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .die_temp (die_temp),
    .hot      (hot_hi)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pg_deglitch #(
      .DEGLITCH_CYCLES (DEGLITCH_CYCLES)
    ) u_dg (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .oc_raw (oc_raw[p]),
      .oc_flt (oc_flt[p])
    );

    pg_port_lock u_lock (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .hot_lo (hot_lo),
      .oc_flt (oc_flt[p]),
      .locked (port_lock[p])
    );

    assign sw_on[p]   = ~en_n[p] & ~port_lock[p] & ~hot_hi & pwr_ready;
    assign fault_n[p] = ~(oc_flt[p] | port_lock[p] | hot_hi);
  end
endmodule

// File: rtl/port_guard_chk.sv
module port_guard_chk #(
  parameter int NUM_PORTS = 4,
  parameter int TEMP_W    = 8,
  parameter int TRIP_LO   = 140,
  parameter int TRIP_HI   = 150,
  parameter int HYST      = 20
) (
  input logic                 clk,
  input logic                 rst_int_n,
  input logic                 pwr_ready,
  input logic [NUM_PORTS-1:0] oc_raw,
  input logic [TEMP_W-1:0]    die_temp,
  input logic [NUM_PORTS-1:0] sw_on,
  input logic [NUM_PORTS-1:0] fault_n,
  input logic [NUM_PORTS-1:0] oc_flt,
  input logic [NUM_PORTS-1:0] port_lock,
  input logic                 hot_lo
);
  localparam logic [TEMP_W-1:0] HI_V     = TEMP_W'(TRIP_HI);
  localparam logic [TEMP_W-1:0] LO_REL_V = TEMP_W'(TRIP_LO - HYST);

  // R2
  pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pwr_ready |-> (sw_on == '0));

  // R8
  hi_trip_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (die_temp >= HI_V) |=> ((sw_on == '0) && (fault_n == '0)));

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_chk
    // R4
    oc_drop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      !oc_raw[k] |=> !oc_flt[k]);

    // R3
    dg_rise_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      $rose(oc_flt[k]) |-> $past(oc_raw[k]));

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      $rose(port_lock[k]) |-> ($past(hot_lo) && $past(oc_flt[k])));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (port_lock[k] && (die_temp > LO_REL_V)) |=> port_lock[k]);
  end
endmodule

bind port_guard_top port_guard_chk #(
  .NUM_PORTS (NUM_PORTS),
  .TEMP_W    (TEMP_W),
  .TRIP_LO   (TRIP_LO),
  .TRIP_HI   (TRIP_HI),
  .HYST      (HYST)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .pwr_ready (pwr_ready),
  .oc_raw    (oc_raw),
  .die_temp  (die_temp),
  .sw_on     (sw_on),
  .fault_n   (fault_n),
  .oc_flt    (oc_flt),
  .port_lock (port_lock),
  .hot_lo    (hot_lo)
);

// File: tb/port_guard_top_test.sv
module port_guard_top_test;
  typedef struct packed {
    logic       pr;
    logic [3:0] en_n;
    logic [3:0] oc;
    logic [7:0] temp;
    logic [7:0] cyc;
    logic [3:0] sw;
    logic [3:0] fn;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    {1'b0, 4'b0000, 4'b0000, 8'd25,  8'd2,  4'b0000, 4'b1111, 4'd2},  // R2 power not ready
    {1'b1, 4'b0101, 4'b0000, 8'd25,  8'd2,  4'b1010, 4'b1111, 4'd1},  // R1 enable pattern
    {1'b1, 4'b0000, 4'b0001, 8'd25,  8'd7,  4'b1111, 4'b1111, 4'd3},  // R3 one edge short
    {1'b1, 4'b0000, 4'b0000, 8'd25,  8'd2,  4'b1111, 4'b1111, 4'd3},  // R3 count restarts
    {1'b1, 4'b0000, 4'b0001, 8'd25,  8'd7,  4'b1111, 4'b1111, 4'd3},  // R3 short again
    {1'b1, 4'b0000, 4'b0001, 8'd25,  8'd1,  4'b1111, 4'b1110, 4'd3},  // R3 eighth edge
    {1'b1, 4'b0000, 4'b0001, 8'd139, 8'd3,  4'b1111, 4'b1110, 4'd5},  // R5 below lower trip
    {1'b1, 4'b0000, 4'b0001, 8'd140, 8'd3,  4'b1110, 4'b1110, 4'd6},  // R6 isolate port 0
    {1'b1, 4'b0000, 4'b0000, 8'd140, 8'd3,  4'b1110, 4'b1110, 4'd7},  // R7 hold without oc
    {1'b1, 4'b0000, 4'b0000, 8'd121, 8'd3,  4'b1110, 4'b1110, 4'd7},  // R7 one above release
    {1'b1, 4'b0000, 4'b0000, 8'd120, 8'd3,  4'b1111, 4'b1111, 4'd7},  // R7 release
    {1'b1, 4'b0000, 4'b0000, 8'd150, 8'd2,  4'b0000, 4'b0000, 4'd8},  // R8 upper trip
    {1'b1, 4'b0000, 4'b0000, 8'd131, 8'd3,  4'b0000, 4'b0000, 4'd9},  // R9 one above release
    {1'b1, 4'b0000, 4'b0000, 8'd130, 8'd2,  4'b1111, 4'b1111, 4'd9},  // R9 release
    {1'b1, 4'b0000, 4'b0110, 8'd145, 8'd10, 4'b1001, 4'b1001, 4'd6},  // R6 two ports isolated
    {1'b1, 4'b1111, 4'b0000, 8'd100, 8'd3,  4'b0000, 4'b1111, 4'd1}   // R1 all disabled
  };

  logic       clk;
  logic       rst_n;
  logic       pwr_ready;
  logic [3:0] en_n;
  logic [3:0] oc_raw;
  logic [7:0] die_temp;
  logic [3:0] sw_on;
  logic [3:0] fault_n;

  int checks;
  int failures;
  bit done;

  port_guard_top uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ready (pwr_ready),
    .en_n      (en_n),
    .oc_raw    (oc_raw),
    .die_temp  (die_temp),
    .sw_on     (sw_on),
    .fault_n   (fault_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input int req, input logic [3:0] exp_sw, input logic [3:0] exp_fn);
    checks++;
    if (sw_on !== exp_sw || fault_n !== exp_fn) begin
      failures++;
      $display("FAIL R%0d: sw_on=%b fault_n=%b expected sw_on=%b fault_n=%b",
               req, sw_on, fault_n, exp_sw, exp_fn);
    end
  endtask

  task automatic run_cycles(input int n);
    for (int c = 0; c < n; c++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 200000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 200000", wd);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    failures  = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    pwr_ready = 1'b1;
    en_n      = 4'b0000;
    oc_raw    = 4'b0000;
    die_temp  = 8'd25;
    run_cycles(3);
    // R10 state held in reset: no faults, no lockouts
    check(10, 4'b1111, 4'b1111);
    rst_n = 1'b1;
    run_cycles(4);

    for (int v = 0; v < NV; v++) begin
      pwr_ready = TBL[v].pr;
      en_n      = TBL[v].en_n;
      oc_raw    = TBL[v].oc;
      die_temp  = TBL[v].temp;
      run_cycles(int'(TBL[v].cyc));
      check(int'(TBL[v].req), TBL[v].sw, TBL[v].fn);
    end

    // R3 / R5: port 3 sustained overcurrent at low temperature
    en_n     = 4'b0000;
    die_temp = 8'd25;
    oc_raw   = 4'b1000;
    run_cycles(8);
    check(3, 4'b1111, 4'b0111);
    // R4: fault releases one edge after the flag drops
    oc_raw = 4'b0000;
    run_cycles(1);
    check(4, 4'b1111, 4'b1111);

    // R10: asynchronous reset clears an active lockout at once
    die_temp = 8'd145;
    oc_raw   = 4'b0010;
    run_cycles(10);
    check(6, 4'b1101, 4'b1101);
    rst_n = 1'b0;
    #1;
    check(10, 4'b1111, 4'b1111);
    oc_raw   = 4'b0000;
    die_temp = 8'd25;
    run_cycles(2);
    rst_n = 1'b1;
    run_cycles(4);
    check(10, 4'b1111, 4'b1111);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule